// File: doc/BRIEF.md
# Parallel Display Bus Cycle Timer

This block times single accesses on an 8080-style parallel display bus. An internal requester hands it one of three request kinds: a command write, a data write or a read. The block then drives the chip-select, write-strobe, read-strobe and command/data (A0) pins for one bus cycle. Every strobe edge sits at a programmed tick offset from the start of the access. A tick is one interface clock, or two when the coarse-granularity control is set.

The timing fields come in as static configuration and are copied when a request is accepted. Values that break an edge-ordering rule are raised to the smallest legal value, and a sticky error flag records that this happened. Read data is sampled on the access-time tick and held on a ready/valid return port. A one-clock done pulse marks the end of each bus cycle. A programmable recovery gap, with chip-select released, follows before the next request can be taken.

Top module: `pbus_cycle_timer`

## Requirements
- R1: After reset, CS, WE and RE are inactive at the default polarity (all three high), A0 is high, done, rd_valid and cfg_err are 0, and req_ready is 1.
- R2: The tick counter is 0 in the first clock after a request is accepted. A tick lasts 1 clock when cfg_half=0 and 2 clocks when cfg_half=1. A strobe is active during every tick t with on <= t < off. CS is active on every access, WE only on writes and RE only on reads.
- R3: For each of WE, RE and CS, an off value that is <= its on value is raised to on+1. The CS off value is then raised to the larger of the adjusted WE off and RE off values if it is below that.
- R4: The WE cycle time is raised to at least the adjusted WE off value, and the RE cycle time to at least the adjusted RE off value. An access time that is <= RE on is raised to RE on + 1.
- R5: done is a one-clock pulse in the first clock of tick E. For a write, E is the larger of the adjusted WE cycle time and CS off. For a read, E is the largest of the adjusted RE cycle time, CS off and access time.
- R6: req_kind 0 is a command write (logical A0 = 0) and 1 is a data write (logical A0 = 1). Codes 2 and 3 (bit 1 set) are reads with logical A0 = 1. During a write access bus_doe is 1 and bus_dout carries the write data. During a read access bus_doe is 0.
- R7: With a polarity bit at 0, CS, WE and RE are active low and A0 is driven at its logical level. With the bit at 1, that pin is inverted. The polarity bits take effect from the next accepted request.
- R8: On a read, bus_din is sampled in the first clock of the tick equal to the adjusted access time. The sample appears on rd_data with rd_valid=1 and stays unchanged until rd_ready is seen.
- R9: After the done clock, req_ready stays 0 and returns to 1 in clock done + 2 + G*T. G is cfg_gap and T is the tick length in clocks.
- R10: req_ready is 0 while rd_valid is 1.
- R11: cfg_err goes to 1 when a request is accepted while any value named in R3 or R4 needs adjusting. It stays 1 until reset.
- R12: Timing, granularity and polarity inputs are copied when a request is accepted. Changing them during the access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cs_on | input | 4 | CS assert tick |
| cfg_cs_off | input | 6 | CS release tick |
| cfg_we_on | input | 4 | WE assert tick |
| cfg_we_off | input | 6 | WE release tick |
| cfg_re_on | input | 4 | RE assert tick |
| cfg_re_off | input | 6 | RE release tick |
| cfg_we_cyc | input | 6 | Write cycle length in ticks |
| cfg_re_cyc | input | 6 | Read cycle length in ticks |
| cfg_acc | input | 6 | Read sample tick |
| cfg_gap | input | 6 | Recovery ticks with CS released |
| cfg_half | input | 1 | 1 selects a two-clock tick |
| cfg_pol_cs | input | 1 | Invert CS |
| cfg_pol_we | input | 1 | Invert WE |
| cfg_pol_re | input | 1 | Invert RE |
| cfg_pol_a0 | input | 1 | Invert A0 |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_kind | input | 2 | 0 command write, 1 data write, 2/3 read |
| req_wdata | input | 16 | Write data |
| done | output | 1 | Bus cycle finished (one clock) |
| cfg_err | output | 1 | Sticky timing-adjustment flag |
| rd_valid | output | 1 | Read data held |
| rd_ready | input | 1 | Read data taken |
| rd_data | output | 16 | Read data |
| bus_cs | output | 1 | Chip select pin |
| bus_we | output | 1 | Write strobe pin |
| bus_re | output | 1 | Read strobe pin |
| bus_a0 | output | 1 | Command/data pin |
| bus_doe | output | 1 | Data bus output enable |
| bus_dout | output | 16 | Data bus output |
| bus_din | input | 16 | Data bus input |

## Verification
The bench builds the block at its default 16-bit data width with the 4-bit on-fields and 6-bit off and cycle fields. Every on value from 0 to 15 and every off, cycle, access and gap value up to 63 is therefore reachable. The bench runs both tick lengths and all polarity settings, so the longest cycles and recovery gaps reach about 126 clocks each. Fully random fields make every clamp of R3 and R4 fire, and reads whose access time exceeds both cycle and CS off exercise the stretched end of R5.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  // Field widths of the timing format
  localparam int TON_W  = 4;
  localparam int TOFF_W = 6;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_GAP    = 2'd2
  } pbus_state_e;

  // Timing fields as programmed
  typedef struct packed {
    logic [TON_W-1:0]  cs_on;
    logic [TON_W-1:0]  we_on;
    logic [TON_W-1:0]  re_on;
    logic [TOFF_W-1:0] cs_off;
    logic [TOFF_W-1:0] we_off;
    logic [TOFF_W-1:0] re_off;
    logic [TOFF_W-1:0] we_cyc;
    logic [TOFF_W-1:0] re_cyc;
    logic [TOFF_W-1:0] acc;
    logic [TOFF_W-1:0] gap;
  } pbus_raw_t;

  // Timing fields after ordering rules are enforced
  typedef struct packed {
    logic [TOFF_W-1:0] cs_on;
    logic [TOFF_W-1:0] cs_off;
    logic [TOFF_W-1:0] we_on;
    logic [TOFF_W-1:0] we_off;
    logic [TOFF_W-1:0] re_on;
    logic [TOFF_W-1:0] re_off;
    logic [TOFF_W-1:0] end_wr;
    logic [TOFF_W-1:0] end_rd;
    logic [TOFF_W-1:0] acc;
    logic [TOFF_W-1:0] gap;
  } pbus_tim_t;

endpackage

// File: rtl/pbus_timing_clamp.sv
module pbus_timing_clamp
  import pbus_pkg::*;
(
  input  pbus_raw_t raw,
  output pbus_tim_t eff,
  output logic      viol
);

  logic [TOFF_W-1:0] we_on, re_on, cs_on;
  logic [TOFF_W-1:0] we_off, re_off, cs_off1, cs_off;
  logic [TOFF_W-1:0] strobe_max, we_cyc, re_cyc, acc, rd_mid;

  always_comb begin
    we_on  = TOFF_W'(raw.we_on);
    re_on  = TOFF_W'(raw.re_on);
    cs_on  = TOFF_W'(raw.cs_on);

    // release must follow assert by at least one tick
    we_off  = (raw.we_off <= we_on) ? we_on + 1'b1 : raw.we_off;
    re_off  = (raw.re_off <= re_on) ? re_on + 1'b1 : raw.re_off;
    cs_off1 = (raw.cs_off <= cs_on) ? cs_on + 1'b1 : raw.cs_off;

    // chip select may not drop before either strobe
    strobe_max = (we_off > re_off) ? we_off : re_off;
    cs_off     = (cs_off1 < strobe_max) ? strobe_max : cs_off1;

    we_cyc = (raw.we_cyc < we_off) ? we_off : raw.we_cyc;
    re_cyc = (raw.re_cyc < re_off) ? re_off : raw.re_cyc;
    acc    = (raw.acc <= re_on) ? re_on + 1'b1 : raw.acc;

    viol = (raw.we_off <= we_on) | (raw.re_off <= re_on) |
           (raw.cs_off <= cs_on) | (cs_off1 < strobe_max) |
           (raw.we_cyc < we_off) | (raw.re_cyc < re_off) |
           (raw.acc <= re_on);

    rd_mid = (re_cyc > cs_off) ? re_cyc : cs_off;

    eff.cs_on  = cs_on;
    eff.cs_off = cs_off;
    eff.we_on  = we_on;
    eff.we_off = we_off;
    eff.re_on  = re_on;
    eff.re_off = re_off;
    eff.end_wr = (we_cyc > cs_off) ? we_cyc : cs_off;
    eff.end_rd = (acc > rd_mid) ? acc : rd_mid;
    eff.acc    = acc;
    eff.gap    = raw.gap;
  end

endmodule

// File: rtl/pbus_tick_pace.sv
module pbus_tick_pace (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic half,
  output logic tick_en,
  output logic tick_first
);

  logic phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (clr)            phase_d = 1'b0;
    else if (run && half) phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  assign tick_en    = !half || phase_q;
  assign tick_first = !phase_q;

endmodule

// File: rtl/pbus_strobe_win.sv
module pbus_strobe_win #(
  parameter int W = 6
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] on_tick,
  input  logic [W-1:0] off_tick,
  input  logic         en,
  output logic         act
);

  assign act = en && (cnt >= on_tick) && (cnt < off_tick);

endmodule

// File: rtl/pbus_cycle_timer.sv
module pbus_cycle_timer
  import pbus_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TON_W-1:0]  cfg_cs_on,
  input  logic [TOFF_W-1:0] cfg_cs_off,
  input  logic [TON_W-1:0]  cfg_we_on,
  input  logic [TOFF_W-1:0] cfg_we_off,
  input  logic [TON_W-1:0]  cfg_re_on,
  input  logic [TOFF_W-1:0] cfg_re_off,
  input  logic [TOFF_W-1:0] cfg_we_cyc,
  input  logic [TOFF_W-1:0] cfg_re_cyc,
  input  logic [TOFF_W-1:0] cfg_acc,
  input  logic [TOFF_W-1:0] cfg_gap,
  input  logic              cfg_half,
  input  logic              cfg_pol_cs,
  input  logic              cfg_pol_we,
  input  logic              cfg_pol_re,
  input  logic              cfg_pol_a0,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [DW-1:0]     req_wdata,
  output logic              done,
  output logic              cfg_err,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DW-1:0]     rd_data,
  output logic              bus_cs,
  output logic              bus_we,
  output logic              bus_re,
  output logic              bus_a0,
  output logic              bus_doe,
  output logic [DW-1:0]     bus_dout,
  input  logic [DW-1:0]     bus_din
);

  localparam int CNT_W = TOFF_W;
  localparam int NSTB  = 3;   // 0: CS, 1: WE, 2: RE
  localparam int NPOL  = NSTB + 1;

  // ---------------- timing adjustment ----------------
  pbus_raw_t raw;
  pbus_tim_t eff;
  logic      viol;

  always_comb begin
    raw.cs_on  = cfg_cs_on;
    raw.we_on  = cfg_we_on;
    raw.re_on  = cfg_re_on;
    raw.cs_off = cfg_cs_off;
    raw.we_off = cfg_we_off;
    raw.re_off = cfg_re_off;
    raw.we_cyc = cfg_we_cyc;
    raw.re_cyc = cfg_re_cyc;
    raw.acc    = cfg_acc;
    raw.gap    = cfg_gap;
  end

  pbus_timing_clamp u_clamp (
    .raw  (raw),
    .eff  (eff),
    .viol (viol)
  );

  // ---------------- state ----------------
  pbus_state_e        state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  pbus_tim_t          tim_q;
  logic               half_q, rd_q, a0_q;
  logic [NPOL-1:0]    pol_q;
  logic [DW-1:0]      wdata_q, rdat_q;
  logic               rdv_q, rdv_d, err_q, err_d;

  logic               accept, at_end, cap, pace_clr, tick_en, tick_first;
  logic [CNT_W-1:0]   end_sel;

  assign req_ready = (state_q == ST_IDLE) && !rdv_q;
  assign accept    = req_valid && req_ready;
  assign end_sel   = rd_q ? tim_q.end_rd : tim_q.end_wr;
  assign at_end    = (cnt_q == end_sel);
  assign pace_clr  = accept || ((state_q == ST_ACTIVE) && at_end);

  pbus_tick_pace u_pace (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (pace_clr),
    .run        (state_q != ST_IDLE),
    .half       (half_q),
    .tick_en    (tick_en),
    .tick_first (tick_first)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_ACTIVE;
          cnt_d   = '0;
        end
      end
      ST_ACTIVE: begin
        if (at_end) begin
          state_d = ST_GAP;
          cnt_d   = '0;
        end else if (tick_en) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt_q == tim_q.gap) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (tick_en) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // per-access copy of configuration and request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim_q   <= '0;
      half_q  <= 1'b0;
      rd_q    <= 1'b0;
      a0_q    <= 1'b1;
      pol_q   <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      tim_q   <= eff;
      half_q  <= cfg_half;
      rd_q    <= req_kind[1];
      a0_q    <= req_kind[1] | req_kind[0];
      pol_q   <= {cfg_pol_a0, cfg_pol_re, cfg_pol_we, cfg_pol_cs};
      wdata_q <= req_wdata;
    end
  end

  // ---------------- strobe windows ----------------
  logic [CNT_W-1:0] w_on  [NSTB];
  logic [CNT_W-1:0] w_off [NSTB];
  logic [NSTB-1:0]  w_en;
  logic [NSTB-1:0]  win_act;
  logic             active;

  assign active   = (state_q == ST_ACTIVE);
  assign w_on[0]  = tim_q.cs_on;
  assign w_off[0] = tim_q.cs_off;
  assign w_on[1]  = tim_q.we_on;
  assign w_off[1] = tim_q.we_off;
  assign w_on[2]  = tim_q.re_on;
  assign w_off[2] = tim_q.re_off;
  assign w_en[0]  = active;
  assign w_en[1]  = active && !rd_q;
  assign w_en[2]  = active && rd_q;

  for (genvar i = 0; i < NSTB; i++) begin : g_win
    pbus_strobe_win #(.W(CNT_W)) u_win (
      .cnt      (cnt_q),
      .on_tick  (w_on[i]),
      .off_tick (w_off[i]),
      .en       (w_en[i]),
      .act      (win_act[i])
    );
  end

  assign bus_cs   = ~(win_act[0] ^ pol_q[0]);
  assign bus_we   = ~(win_act[1] ^ pol_q[1]);
  assign bus_re   = ~(win_act[2] ^ pol_q[2]);
  assign bus_a0   = a0_q ^ pol_q[3];
  assign bus_doe  = active && !rd_q;
  assign bus_dout = wdata_q;
  assign done     = active && at_end;

  // ---------------- read capture and error flag ----------------
  assign cap = active && rd_q && tick_first && (cnt_q == tim_q.acc);

  always_comb begin
    rdv_d = rdv_q;
    if (cap)           rdv_d = 1'b1;
    else if (rd_ready) rdv_d = 1'b0;
    err_d = err_q | (accept & viol);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdv_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      rdv_q <= rdv_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdat_q <= '0;
    else if (cap) rdat_q <= bus_din;
  end

  assign rd_valid = rdv_q;
  assign rd_data  = rdat_q;
  assign cfg_err  = err_q;

endmodule

// File: rtl/pbus_cycle_timer_chk.sv
module pbus_cycle_timer_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    act,
  input logic          done,
  input logic          req_ready,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data,
  input logic          cfg_err,
  input logic          bus_doe
);

  p_we_re_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(act[1] && act[2]));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_doe_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> !act[2]);

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (act == 3'b000 && !bus_doe && !done));

  p_rd_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !req_ready);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

endmodule

bind pbus_cycle_timer pbus_cycle_timer_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .act       (win_act),
  .done      (done),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .cfg_err   (cfg_err),
  .bus_doe   (bus_doe)
);

// File: tb/pbus_cycle_timer_test.sv
`timescale 1ns/1ps
module pbus_cycle_timer_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int c_cs_on, c_cs_off, c_we_on, c_we_off, c_re_on, c_re_off;
  int c_we_cyc, c_re_cyc, c_acc, c_gap;
  bit c_half, c_pcs, c_pwe, c_pre, c_pa0;

  logic        req_valid = 1'b0;
  logic [1:0]  req_kind  = 2'd0;
  logic [15:0] req_wdata = 16'd0;
  logic        rd_ready  = 1'b0;
  logic [15:0] bus_din   = 16'd0;
  logic req_ready, done, cfg_err, rd_valid;
  logic bus_cs, bus_we, bus_re, bus_a0, bus_doe;
  logic [15:0] rd_data, bus_dout;

  int n_chk = 0;
  int n_err = 0;
  bit exp_err = 1'b0;
  bit finished = 1'b0;

  pbus_cycle_timer #(.DW(16)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_cs_on(4'(c_cs_on)), .cfg_cs_off(6'(c_cs_off)),
    .cfg_we_on(4'(c_we_on)), .cfg_we_off(6'(c_we_off)),
    .cfg_re_on(4'(c_re_on)), .cfg_re_off(6'(c_re_off)),
    .cfg_we_cyc(6'(c_we_cyc)), .cfg_re_cyc(6'(c_re_cyc)),
    .cfg_acc(6'(c_acc)), .cfg_gap(6'(c_gap)),
    .cfg_half(c_half), .cfg_pol_cs(c_pcs), .cfg_pol_we(c_pwe),
    .cfg_pol_re(c_pre), .cfg_pol_a0(c_pa0),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_wdata(req_wdata), .done(done), .cfg_err(cfg_err),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .bus_cs(bus_cs), .bus_we(bus_we), .bus_re(bus_re), .bus_a0(bus_a0),
    .bus_doe(bus_doe), .bus_dout(bus_dout), .bus_din(bus_din)
  );

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int fix_off(int on, int off);
    return (off <= on) ? on + 1 : off;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic rand_common();
    c_gap  = int'($urandom % 4);
    c_half = 1'($urandom);
    c_pcs  = 1'($urandom);
    c_pwe  = 1'($urandom);
    c_pre  = 1'($urandom);
    c_pa0  = 1'($urandom);
  endtask

  task automatic rand_legal();
    c_we_on  = int'($urandom % 16);
    c_we_off = c_we_on + 1 + int'($urandom % 6);
    c_re_on  = int'($urandom % 16);
    c_re_off = c_re_on + 1 + int'($urandom % 6);
    c_cs_on  = int'($urandom % 16);
    c_cs_off = mx(mx(c_cs_on + 1, c_we_off), c_re_off) + int'($urandom % 3);
    c_we_cyc = c_we_off + int'($urandom % 4);
    c_re_cyc = c_re_off + int'($urandom % 4);
    c_acc    = c_re_on + 1 + int'($urandom % 5);
    rand_common();
  endtask

  task automatic rand_any();
    c_we_on  = int'($urandom % 16);
    c_re_on  = int'($urandom % 16);
    c_cs_on  = int'($urandom % 16);
    c_we_off = int'($urandom % 64);
    c_re_off = int'($urandom % 64);
    c_cs_off = int'($urandom % 64);
    c_we_cyc = int'($urandom % 64);
    c_re_cyc = int'($urandom % 64);
    c_acc    = int'($urandom % 64);
    rand_common();
    c_gap    = int'($urandom % 64);
  endtask

  // One access; expectations come from the requirement formulas
  task automatic run_one(input int kind, input bit scramble);
    int T, cson, weon, reon, wo, ro, co, wc, rc, ac, en, D, P;
    bit rd, viol, pcs, pwe, pre, pa0, wbad, dbad, rbad;
    int wact, wexp, dk, rk, base;
    logic [15:0] wd, expd;
    T    = c_half ? 2 : 1;
    cson = c_cs_on; weon = c_we_on; reon = c_re_on;
    wo   = fix_off(c_we_on, c_we_off);
    ro   = fix_off(c_re_on, c_re_off);
    co   = mx(fix_off(c_cs_on, c_cs_off), mx(wo, ro));
    wc   = mx(c_we_cyc, wo);
    rc   = mx(c_re_cyc, ro);
    ac   = (c_acc <= c_re_on) ? c_re_on + 1 : c_acc;
    viol = (c_we_off <= c_we_on) || (c_re_off <= c_re_on) ||
           (c_cs_off <= c_cs_on) ||
           (fix_off(c_cs_on, c_cs_off) < mx(wo, ro)) ||
           (c_we_cyc < wo) || (c_re_cyc < ro) || (c_acc <= c_re_on);
    rd   = (kind >= 2);
    en   = rd ? mx(mx(rc, co), ac) : mx(wc, co);
    D    = en * T;
    P    = c_gap;
    pcs = c_pcs; pwe = c_pwe; pre = c_pre; pa0 = c_pa0;
    wd   = 16'($urandom);
    base = int'($urandom % 65536);
    expd = 16'(base + ac * T);
    wbad = 1'b0; dbad = 1'b0; rbad = 1'b0;
    wact = 0; wexp = 0; dk = -1; rk = -1;

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_kind  = 2'(kind);
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;

    for (int k = 0; k <= D; k++) begin
      int t;
      bit ecs, ewe, ere;
      logic [4:0] e, a;
      t   = k / T;
      ecs = (t >= cson) && (t < co);
      ewe = !rd && (t >= weon) && (t < wo);
      ere = rd && (t >= reon) && (t < ro);
      e   = {~(ecs ^ pcs), ~(ewe ^ pwe), ~(ere ^ pre), (kind != 0) ^ pa0, !rd};
      a   = {bus_cs, bus_we, bus_re, bus_a0, bus_doe};
      if (!wbad && ((a !== e) || (!rd && bus_dout !== wd))) begin
        wbad = 1'b1; wact = int'(a); wexp = int'(e);
      end
      if (!dbad && (done !== (k == D))) begin
        dbad = 1'b1; dk = k;
      end
      bus_din = 16'(base + k);
      if (scramble && k == 0) rand_any();
      @(negedge clk);
    end
    check(!wbad, "R2/R3/R4/R6/R7/R12", "pin levels {cs,we,re,a0,doe}", wact, wexp);
    check(!dbad, "R5", "done clock mismatch at index", dk, D);

    // recovery gap: clock index D+j
    for (int j = 1; j <= 2 + P * T; j++) begin
      bit er;
      er = !rd && (j == 2 + P * T);
      if (!rbad && (req_ready !== er)) begin
        rbad = 1'b1; rk = j;
      end
      if (j < 2 + P * T) @(negedge clk);
    end
    check(!rbad, "R9/R10", "req_ready wrong at clock after done", rk, 2 + P * T);

    if (rd) begin
      check(rd_valid === 1'b1, "R8", "rd_valid held", int'(rd_valid), 1);
      check(rd_data === expd, "R8", "read sample", int'(rd_data), int'(expd));
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
      check(rd_valid === 1'b0 && req_ready === 1'b1, "R10", "release after rd_ready",
            int'({rd_valid, req_ready}), 1);
    end

    exp_err = exp_err | viol;
    check(cfg_err === exp_err, "R11", "cfg_err", int'(cfg_err), int'(exp_err));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    rand_legal();
    c_pcs = 1'b0; c_pwe = 1'b0; c_pre = 1'b0; c_pa0 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({bus_cs, bus_we, bus_re, bus_a0} === 4'b1111, "R1", "idle pins",
          int'({bus_cs, bus_we, bus_re, bus_a0}), 15);
    check({done, rd_valid, cfg_err, req_ready} === 4'b0001, "R1", "idle flags",
          int'({done, rd_valid, cfg_err, req_ready}), 1);

    // legal configurations: cfg_err must stay clear (R11)
    for (int i = 0; i < 16; i++) begin
      rand_legal();
      run_one(int'($urandom % 4), 1'b1);
    end

    // directed: everything zero, one-clock tick, command write (clamps of R3/R4)
    c_cs_on = 0; c_cs_off = 0; c_we_on = 0; c_we_off = 0; c_re_on = 0; c_re_off = 0;
    c_we_cyc = 0; c_re_cyc = 0; c_acc = 0; c_gap = 0;
    c_half = 1'b0; c_pcs = 1'b0; c_pwe = 1'b0; c_pre = 1'b0; c_pa0 = 1'b0;
    run_one(0, 1'b0);
    // directed: read whose access time outlasts cycle and CS (R5 stretch)
    rand_legal();
    c_acc = 50; c_half = 1'b1;
    run_one(2, 1'b1);
    // directed: extreme fields, two-clock tick, long gap
    c_cs_on = 15; c_we_on = 15; c_re_on = 15; c_cs_off = 63; c_we_off = 63;
    c_re_off = 63; c_we_cyc = 63; c_re_cyc = 63; c_acc = 63; c_gap = 63; c_half = 1'b1;
    run_one(1, 1'b0);
    run_one(3, 1'b0);

    // fully random fields
    for (int i = 0; i < 30; i++) begin
      rand_any();
      run_one(int'($urandom % 4), 1'($urandom));
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule